// File: doc/BRIEF.md
# I2C Master Register Front End with Byte FIFOs

This block is the software-facing half of an I2C master. A host reaches it through a simple word-addressed register port. It stores configuration values, holds transmit and receive bytes in two 8-entry FIFOs, and keeps sticky interrupt flags that the host can mask and clear.

Transmit and receive share one data address. A write there queues a tagged entry. If bit 8 of the entry is set, the entry is an address command for the target. Otherwise it is a plain data byte. A read from the same address takes the oldest received byte.

The queued entries go to a separate bit-level engine through a valid/ready command port. That engine reports received bytes, missing acknowledges, lost arbitration, bus START/STOP detection and stop completion back to this block on single-cycle event inputs. Timing values such as the cycle, low period and setup times are only stored here and made available for the engine to read. The serial timing itself is generated elsewhere.

Top module: `i2c_fifo_regs`

## Requirements
- R1: After reset the status word reads 0x0000_0003 (bit 0 TX empty, bit 1 TX not full), the control word reads 0, `irq` is 0 and `cmd_valid` is 0.
- R2: A write to byte offset 0x04 queues bits 8:0 of the write data. Queued entries appear on `cmd_data` in write order, and `cmd_valid && cmd_ready` removes the head. `cmd_valid` stays 0 while bit 1 of the bus-control word (offset 0x50) is 0; `eng_run` mirrors that bit.
- R3: The TX FIFO holds 8 entries. A write to a full FIFO is dropped and leaves the stored entries unchanged. While the FIFO is full, status bit 1 reads 0.
- R4: Each `rsp_valid` pulse stores `rsp_byte` in the RX FIFO (8 entries; a byte arriving while it is full is dropped). A read of offset 0x04 returns and removes the oldest byte, or returns 0 when the FIFO is empty. Status bit 2 reads 1 when the RX FIFO is not empty and status bit 3 reads 1 when it is full.
- R5: The interrupt status word (0x20) uses bit 9 for TX-empty, bit 4 for received-count, bit 2 for no-acknowledge and bit 1 for arbitration-lost. These bits are sticky. Writing 1s to offset 0x28 clears the matching bits. If an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: Bit 9 of the interrupt status sets one cycle after the TX FIFO changes from non-empty to empty.
- R7: With a receive count setting (0x44) of 0, bit 4 sets on every received byte. With a setting N>0, bit 4 sets when the N-th byte arrives. 0x4C counts received bytes and 0x48 counts data (non-address) entries taken by the engine. A write to 0x44 clears the receive counter and a write to 0x40 clears the transmit counter.
- R8: `irq` is 1 exactly when some interrupt status bit is set and the same bit is set in the enable word (0x24).
- R9: Bit 2 of the reset word (0x34) empties the TX FIFO and bit 1 empties the RX FIFO. Each bit reads 1 in the cycle after the write and clears itself on the next clock edge, when the flush takes place.
- R10: Bit 0 of the reset word drives `bus_reset_req`. It stays set until `bus_reset_done` is pulsed.
- R11: A control write with bit 2 (start) set makes status bit 12 (device busy) 1. The bit returns to 0 on `evt_stop_done`. Status bit 8 (bus busy) sets on `evt_start_seen` and clears on `evt_stop_seen`. Control bit 2 clears on `evt_start_seen` and control bit 1 (stop) clears on `evt_stop_done`. Control bits 3:0 drive `ctl`.
- R12: The timing words at 0x0C, 0x10, 0x14, 0x18, 0x1C and 0x3C read back their low 16 written bits. Offsets 0x08 and 0x30 read 0 and ignore writes. 0x38 reads {scl_in, sda_in} in bits 1:0. Bit 0 of 0x50 drives `scl_release`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| acc_en | input | 1 | register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 7 | byte offset |
| acc_wdata | input | 32 | write data |
| acc_rdata | output | 32 | read data, valid while `acc_en` is high |
| cmd_valid | output | 1 | TX head is offered to the engine |
| cmd_data | output | 9 | TX head; bit 8 marks an address command |
| cmd_ready | input | 1 | engine takes the head |
| rsp_valid | input | 1 | engine delivers a received byte |
| rsp_byte | input | 8 | received byte |
| evt_nack | input | 1 | target did not acknowledge |
| evt_arb_lost | input | 1 | arbitration lost |
| evt_start_seen | input | 1 | START observed on the bus |
| evt_stop_seen | input | 1 | STOP observed on the bus |
| evt_stop_done | input | 1 | requested stop completed |
| ctl | output | 4 | master, start, stop, nack-next request bits |
| eng_run | output | 1 | engine enabled for normal operation |
| scl_release | output | 1 | release a clock line held low |
| bus_reset_req | output | 1 | forced bus reset request |
| bus_reset_done | input | 1 | forced bus reset finished |
| scl_in | input | 1 | sampled clock line |
| sda_in | input | 1 | sampled data line |
| irq | output | 1 | interrupt request |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is an engine event and a software clear of the same interrupt bit. The bench drives `evt_nack` in the same cycle as a write of 1 to bit 2 of the clear register. It then reads the status word back and expects the bit to still be set, because losing the event would be worse than keeping a stale flag.

The second pair is a flush and the FIFO data paths. The bench reads the reset word in the cycle after writing it and expects the self-clearing bit to still be 1. On the following read it expects the bit to be 0 and the FIFO to be empty.

// File: rtl/i2c_fifo_regs.sv
module i2c_fifo_regs #(
  parameter int DEPTH = 8,
  parameter int CFG_W = 16,
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [6:0]  acc_addr,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        cmd_valid,
  output logic [8:0]  cmd_data,
  input  logic        cmd_ready,
  input  logic        rsp_valid,
  input  logic [7:0]  rsp_byte,
  input  logic        evt_nack,
  input  logic        evt_arb_lost,
  input  logic        evt_start_seen,
  input  logic        evt_stop_seen,
  input  logic        evt_stop_done,
  output logic [3:0]  ctl,
  output logic        eng_run,
  output logic        scl_release,
  output logic        bus_reset_req,
  input  logic        bus_reset_done,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [31:0] IMASK = 32'h0000_0216;

  localparam logic [4:0] W_CTL = 5'd0,  W_DAT = 5'd1,  W_SLV = 5'd3,  W_CYC = 5'd4;
  localparam logic [4:0] W_LOW = 5'd5,  W_RSU = 5'd6,  W_DSU = 5'd7,  W_IST = 5'd8;
  localparam logic [4:0] W_IEN = 5'd9,  W_ICL = 5'd10, W_STA = 5'd11, W_RST = 5'd13;
  localparam logic [4:0] W_MON = 5'd14, W_NSE = 5'd15, W_TBC = 5'd16, W_RBC = 5'd17;
  localparam logic [4:0] W_TBM = 5'd18, W_RBM = 5'd19, W_BRS = 5'd20;

  wire [4:0] widx = acc_addr[6:2];
  wire unused_addr = ^acc_addr[1:0];
  wire wr = acc_en & acc_wr;
  wire rd = acc_en & ~acc_wr;
  function automatic logic hit(input logic [4:0] w, input logic [4:0] idx);
    return w == idx;
  endfunction

  logic [8:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [3:0]    ctl_q;
  logic [1:0]    brst_q;
  logic [2:0]    rst_q;
  logic [31:0]   intr, ien;
  logic [CFG_W-1:0] c_slv, c_cyc, c_low, c_rsu, c_dsu, c_nse;
  logic [CNT_W-1:0] tbc, rbc, tbcm, rbcm;
  logic dev_busy, bus_busy, tx_empty_q;

  wire tx_empty = tx_cnt == '0;
  wire tx_full  = tx_cnt == FULL;
  wire rx_empty = rx_cnt == '0;
  wire rx_full  = rx_cnt == FULL;

  assign eng_run       = brst_q[1];
  assign scl_release   = brst_q[0];
  assign bus_reset_req = rst_q[0];
  assign ctl           = ctl_q;
  assign cmd_valid     = eng_run & ~tx_empty;
  assign cmd_data      = tx_mem[tx_rp];
  assign irq           = |(intr & ien);

  wire tx_push  = wr & hit(widx, W_DAT) & ~tx_full;
  wire tx_pop   = cmd_valid & cmd_ready;
  wire rx_push  = rsp_valid & ~rx_full;
  wire rx_pop   = rd & hit(widx, W_DAT) & ~rx_empty;
  wire start_wr = wr & hit(widx, W_CTL) & acc_wdata[2];

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= acc_wdata[8:0];
    if (rx_push) rx_mem[rx_wp] <= rsp_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (rst_q[2]) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rst_q[1]) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  wire te_evt = tx_empty & ~tx_empty_q;
  wire rb_evt = rsp_valid & ((rbc == '0) | (rbcm + 1'b1 == rbc));
  wire [31:0] iset = {22'd0, te_evt, 4'd0, rb_evt, 1'b0, evt_nack, evt_arb_lost, 1'b0};
  wire [31:0] iclr = (wr & hit(widx, W_ICL)) ? (acc_wdata & IMASK) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr <= '0; ien <= '0; tx_empty_q <= 1'b1;
      tbcm <= '0; rbcm <= '0;
    end else begin
      tx_empty_q <= tx_empty;
      intr <= (intr & ~iclr) | iset;
      if (wr & hit(widx, W_IEN)) ien <= acc_wdata & IMASK;
      if (wr & hit(widx, W_RBC)) rbcm <= '0;
      else if (rsp_valid)        rbcm <= rbcm + 1'b1;
      if (wr & hit(widx, W_TBC)) tbcm <= '0;
      else if (tx_pop & ~cmd_data[8]) tbcm <= tbcm + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; brst_q <= '0; rst_q <= '0;
      dev_busy <= 1'b0; bus_busy <= 1'b0;
      c_slv <= '0; c_cyc <= '0; c_low <= '0; c_rsu <= '0; c_dsu <= '0; c_nse <= '0;
      tbc <= '0; rbc <= '0;
    end else begin
      if (wr & hit(widx, W_CTL)) ctl_q <= acc_wdata[3:0];
      else begin
        if (evt_start_seen) ctl_q[2] <= 1'b0;
        if (evt_stop_done)  ctl_q[1] <= 1'b0;
      end
      if (start_wr)           dev_busy <= 1'b1;
      else if (evt_stop_done) dev_busy <= 1'b0;
      if (evt_start_seen)     bus_busy <= 1'b1;
      else if (evt_stop_seen) bus_busy <= 1'b0;
      rst_q[2] <= wr & hit(widx, W_RST) & acc_wdata[2];
      rst_q[1] <= wr & hit(widx, W_RST) & acc_wdata[1];
      if (wr & hit(widx, W_RST) & acc_wdata[0]) rst_q[0] <= 1'b1;
      else if (bus_reset_done)                  rst_q[0] <= 1'b0;
      if (wr) begin
        case (widx)
          W_BRS: brst_q <= acc_wdata[1:0];
          W_SLV: c_slv  <= acc_wdata[CFG_W-1:0];
          W_CYC: c_cyc  <= acc_wdata[CFG_W-1:0];
          W_LOW: c_low  <= acc_wdata[CFG_W-1:0];
          W_RSU: c_rsu  <= acc_wdata[CFG_W-1:0];
          W_DSU: c_dsu  <= acc_wdata[CFG_W-1:0];
          W_NSE: c_nse  <= acc_wdata[CFG_W-1:0];
          W_TBC: tbc    <= acc_wdata[CNT_W-1:0];
          W_RBC: rbc    <= acc_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  wire [31:0] status = {19'd0, dev_busy, 3'd0, bus_busy, 4'd0,
                        rx_full, ~rx_empty, ~tx_full, tx_empty};

  always_comb begin
    case (widx)
      W_CTL: acc_rdata = {28'd0, ctl_q};
      W_DAT: acc_rdata = rx_empty ? 32'd0 : {24'd0, rx_mem[rx_rp]};
      W_SLV: acc_rdata = 32'(c_slv);
      W_CYC: acc_rdata = 32'(c_cyc);
      W_LOW: acc_rdata = 32'(c_low);
      W_RSU: acc_rdata = 32'(c_rsu);
      W_DSU: acc_rdata = 32'(c_dsu);
      W_IST: acc_rdata = intr;
      W_IEN: acc_rdata = ien;
      W_STA: acc_rdata = status;
      W_RST: acc_rdata = {29'd0, rst_q};
      W_MON: acc_rdata = {30'd0, scl_in, sda_in};
      W_NSE: acc_rdata = 32'(c_nse);
      W_TBC: acc_rdata = 32'(tbc);
      W_RBC: acc_rdata = 32'(rbc);
      W_TBM: acc_rdata = 32'(tbcm);
      W_RBM: acc_rdata = 32'(rbcm);
      W_BRS: acc_rdata = {30'd0, brst_q};
      default: acc_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/i2c_fifo_regs_chk.sv
module i2c_fifo_regs_chk #(
  parameter int DEPTH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [$clog2(DEPTH):0] tx_cnt,
  input logic [$clog2(DEPTH):0] rx_cnt,
  input logic [2:0]             rst_q,
  input logic [31:0]            intr,
  input logic                   dev_busy,
  input logic                   start_wr,
  input logic                   evt_nack,
  input logic                   evt_stop_done,
  input logic                   bus_reset_done
);
  localparam int CW = $clog2(DEPTH) + 1;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  a_r9_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q[2] |=> tx_cnt == '0);
  a_r9_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q[1] |=> rx_cnt == '0);
  a_r5_nack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt_nack |=> intr[2]);
  a_r10_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q[0] && !bus_reset_done) |=> rst_q[0]);
  a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_stop_done && !start_wr) |=> !dev_busy);
endmodule

bind i2c_fifo_regs i2c_fifo_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rst_q(rst_q),
  .intr(intr), .dev_busy(dev_busy), .start_wr(start_wr), .evt_nack(evt_nack),
  .evt_stop_done(evt_stop_done), .bus_reset_done(bus_reset_done)
);

// File: tb/i2c_fifo_regs_test.sv
module i2c_fifo_regs_test;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0;
  logic [6:0] acc_addr = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic cmd_valid, cmd_ready = 0;
  logic [8:0] cmd_data;
  logic rsp_valid = 0;
  logic [7:0] rsp_byte = 0;
  logic evt_nack = 0, evt_arb_lost = 0, evt_start_seen = 0, evt_stop_seen = 0, evt_stop_done = 0;
  logic [3:0] ctl;
  logic eng_run, scl_release, bus_reset_req, bus_reset_done = 0;
  logic scl_in = 1, sda_in = 0, irq;
  int checks = 0, fails = 0;
  logic [31:0] d;

  always #5 clk = ~clk;

  i2c_fifo_regs uut (.*);

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] v);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = v;
    @(posedge clk); #1 acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk); acc_en = 1; acc_wr = 0; acc_addr = a;
    #1 v = acc_rdata;
    @(posedge clk); #1 acc_en = 0;
  endtask

  task automatic take(input string r, input logic [8:0] exp);
    @(negedge clk);
    check(r, {22'd0, cmd_valid, cmd_data}, {22'd0, 1'b1, exp});
    cmd_ready = 1;
    @(posedge clk); #1 cmd_ready = 0;
  endtask

  task automatic rx_in(input logic [7:0] b);
    @(negedge clk); rsp_valid = 1; rsp_byte = b;
    @(posedge clk); #1 rsp_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset;
    rd(7'h2C, d); check("R1 status", d, 32'h3);
    rd(7'h00, d); check("R1 control", d, 0);
    check("R1 irq/cmd_valid", {30'd0, irq, cmd_valid}, 0);
  endtask

  task automatic t_config;
    wr(7'h10, 32'hABCD_01F4); rd(7'h10, d); check("R12 cycle readback", d, 32'h01F4);
    wr(7'h3C, 32'h0007);      rd(7'h3C, d); check("R12 noise readback", d, 32'h7);
    wr(7'h08, 32'hFFFF_FFFF); rd(7'h08, d); check("R12 hole 0x08", d, 0);
    wr(7'h30, 32'hFFFF_FFFF); rd(7'h30, d); check("R12 hole 0x30", d, 0);
    rd(7'h38, d); check("R12 line monitor", d, 32'h2);
  endtask

  task automatic t_tx_order;
    wr(7'h04, 32'h1A5); wr(7'h04, 32'h33); wr(7'h04, 32'h44);
    @(negedge clk); check("R2 held idle", {31'd0, cmd_valid}, 0);
    wr(7'h50, 32'h3);
    check("R12 scl_release/eng_run", {30'd0, eng_run, scl_release}, 3);
    take("R2 addr cmd", 9'h1A5);
    take("R2 data 1", 9'h033);
    take("R2 data 2", 9'h044);
    idle(2);
    rd(7'h20, d); check("R6 tx empty flag", d, 32'h200);
    rd(7'h48, d); check("R7 tx byte monitor", d, 2);
    wr(7'h40, 0); rd(7'h48, d); check("R7 tx monitor clear", d, 0);
  endtask

  task automatic t_tx_full;
    for (int i = 0; i < 9; i++) wr(7'h04, 32'(i + 16));
    rd(7'h2C, d); check("R3 full status", d, 0);
    for (int i = 0; i < 8; i++) take("R3 kept order", 9'(i + 16));
    @(negedge clk); check("R3 ninth dropped", {31'd0, cmd_valid}, 0);
    idle(2);
    wr(7'h28, 32'h200); rd(7'h20, d); check("R5 clear", d, 0);
  endtask

  task automatic t_rx;
    rx_in(8'h11); rx_in(8'h22); rx_in(8'h33);
    rd(7'h2C, d); check("R4 rx not empty", d & 32'hC, 32'h4);
    rd(7'h20, d); check("R7 count 0 fires", d & 32'h10, 32'h10);
    rd(7'h04, d); check("R4 pop 1", d, 32'h11);
    rd(7'h04, d); check("R4 pop 2", d, 32'h22);
    rd(7'h04, d); check("R4 pop 3", d, 32'h33);
    rd(7'h04, d); check("R4 empty pop", d, 0);
    for (int i = 0; i < 9; i++) rx_in(8'(i + 1));
    rd(7'h2C, d); check("R4 rx full", d & 32'hC, 32'hC);
    for (int i = 0; i < 8; i++) begin
      rd(7'h04, d); check("R4 full order", d, 32'(i + 1));
    end
    rd(7'h04, d); check("R4 ninth dropped", d, 0);
  endtask

  task automatic t_rb_count;
    wr(7'h44, 3); wr(7'h28, 32'h216);
    rx_in(8'hA1); rx_in(8'hA2);
    rd(7'h20, d); check("R7 before N", d & 32'h10, 0);
    rx_in(8'hA3);
    rd(7'h20, d); check("R7 at N", d & 32'h10, 32'h10);
    rd(7'h4C, d); check("R7 rx monitor", d, 3);
    wr(7'h34, 32'h2);
    rd(7'h34, d); check("R9 bit reads 1", d, 32'h2);
    rd(7'h34, d); check("R9 self clear", d, 0);
    rd(7'h2C, d); check("R9 rx flushed", d & 32'h4, 0);
    wr(7'h44, 0);
  endtask

  task automatic t_tx_flush;
    wr(7'h50, 0);
    wr(7'h04, 32'h55); wr(7'h04, 32'h66);
    rd(7'h2C, d); check("R9 tx loaded", d & 32'h1, 0);
    wr(7'h34, 32'h4);
    rd(7'h34, d); check("R9 tx bit reads 1", d, 32'h4);
    rd(7'h2C, d); check("R9 tx flushed", d & 32'h1, 1);
    idle(2);
  endtask

  task automatic t_irq;
    wr(7'h28, 32'h216);
    wr(7'h24, 32'h4);
    @(negedge clk); evt_nack = 1; @(posedge clk); #1 evt_nack = 0;
    @(negedge clk); check("R8 irq on", {31'd0, irq}, 1);
    @(negedge clk); evt_arb_lost = 1; @(posedge clk); #1 evt_arb_lost = 0;
    rd(7'h20, d); check("R5 sticky bits", d, 32'h6);
    wr(7'h24, 0);
    @(negedge clk); check("R8 masked", {31'd0, irq}, 0);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_addr = 7'h28; acc_wdata = 32'h4; evt_nack = 1;
    @(posedge clk); #1 acc_en = 0; acc_wr = 0; evt_nack = 0;
    rd(7'h20, d); check("R5 set wins", d, 32'h6);
    wr(7'h28, 32'h6); rd(7'h20, d); check("R5 cleared", d, 0);
  endtask

  task automatic t_busy;
    wr(7'h00, 32'hC);
    check("R11 ctl out", {28'd0, ctl}, 32'hC);
    rd(7'h2C, d); check("R11 device busy", d, 32'h1003);
    @(negedge clk); evt_start_seen = 1; @(posedge clk); #1 evt_start_seen = 0;
    rd(7'h2C, d); check("R11 bus busy", d, 32'h1103);
    check("R11 start cleared", {28'd0, ctl}, 32'h8);
    wr(7'h00, 32'hA);
    @(negedge clk); evt_stop_done = 1; @(posedge clk); #1 evt_stop_done = 0;
    @(negedge clk); evt_stop_seen = 1; @(posedge clk); #1 evt_stop_seen = 0;
    rd(7'h2C, d); check("R11 idle again", d, 32'h3);
    check("R11 stop cleared", {28'd0, ctl}, 32'h8);
  endtask

  task automatic t_bus_reset;
    wr(7'h34, 32'h1);
    idle(4);
    @(negedge clk); check("R10 req held", {31'd0, bus_reset_req}, 1);
    rd(7'h34, d); check("R10 readback", d, 1);
    @(negedge clk); bus_reset_done = 1; @(posedge clk); #1 bus_reset_done = 0;
    @(negedge clk); check("R10 released", {31'd0, bus_reset_req}, 0);
  endtask

  bit finished = 0;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_config; t_tx_order; t_tx_full; t_rx; t_rb_count;
    t_tx_flush; t_irq; t_busy; t_bus_reset;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule